// File: doc/BRIEF.md
# Data Cache Tag State Validator

This block checks the tags of one set of a four-way data cache, one way per clock. For each way it receives the upper tag word, which holds the coherence state and the replacement order, and the lower tag word, which holds the physical tag and its two parity bits. It also receives the set index. It maps the five-bit coherence state onto one of six legal codes or an error code. For a legal entry it checks both parity bits of the physical tag. It also rebuilds the line's physical address.

A set check starts with a beat that carries `setStart`, which is way 0. The next three beats are ways 1 to 3. The block reports the result of each way and keeps the state and address error flags for the whole set until the next set starts. It keeps the replacement order taken from way 0. It marks the beat that completes the set.

Top module: `dctag_validator`

## Requirements
- R1: The coherence state is `tagHi[29:25]`. `stateCode` encodes it as follows: 0x00→0 (invalid), 0x0F→1 (coherent shared), 0x13→2 (non-coherent exclusive clean), 0x19→3 (non-coherent exclusive dirty), 0x16→4 (coherent exclusive clean), 0x1C→5 (coherent exclusive dirty). Every other state value gives 7.
- R2: A state value outside the six legal ones sets `wayStateErr`. For that way `wayAddrErr` stays low, whatever the parity bits hold.
- R3: For a legal state, `wayAddrErr` is set when the even-parity XOR of `tagLo[39:26]` differs from `tagLo[11]`.
- R4: For a legal state, `wayAddrErr` is set when the even-parity XOR of `tagLo[25:13]` differs from `tagLo[10]`.
- R5: `physAddr` equals `{tagLo[39:13], setIdx[12:0]}`. The other low tag bits have no effect on it.
- R6: `setStateErr` and `setAddrErr` are the OR of the way flags of every beat since the last `setStart` beat, including the current beat. A `setStart` beat drops the flags of earlier beats.
- R7: `lruOrder` takes `tagHi[21:14]` from the way-0 beat only. Bits [1:0] name the least recently used way and bits [7:6] the most recently used. Beats of ways 1 to 3 leave it unchanged.
- R8: A beat with `tagValid` produces `outValid` and all its per-way results on the next clock edge. `outWay` is 0 on a `setStart` beat and otherwise counts up from the previous beat, wrapping after 3. `setDone` is high exactly when `outWay` is 3.
- R9: After reset `outValid`, `setDone`, both set flags, `lruOrder` and `stateCode` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tagValid | input | 1 | A way's tags are present this cycle |
| setStart | input | 1 | This beat is way 0 of a new set |
| tagHi | input | 32 | Upper tag word: state and replacement order |
| tagLo | input | 40 | Lower tag word: physical tag and parity |
| setIdx | input | 13 | Set index and offset bits of the address |
| outValid | output | 1 | Per-way results are valid |
| outWay | output | 2 | Way number of the reported result |
| stateCode | output | 3 | Encoded coherence state (R1) |
| wayStateErr | output | 1 | Illegal state in this way |
| wayAddrErr | output | 1 | Tag parity error in this way |
| physAddr | output | 40 | Reconstructed physical line address |
| setStateErr | output | 1 | Accumulated state error for the set |
| setAddrErr | output | 1 | Accumulated address error for the set |
| lruOrder | output | 8 | Replacement order from way 0 |
| setDone | output | 1 | The result of way 3 is being reported |

## Verification
Every result of a beat is due on the clock edge that follows it. The per-way fields, the address and the set flags all come from that single edge. The driver pushes the expected item for a beat in the same half-cycle in which it drives the beat. The monitor looks at the outputs shortly after each rising edge. There it pairs `outValid` with exactly one queued item, and it flags a queued item that did not appear on that edge. Beats run back to back and with idle gaps. A new set is also started partway through another, so that the set flags, the way count and the replacement order are checked against a model of the whole history of beats.

// File: rtl/dctag_pkg.sv
package dctag_pkg;

  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int STATE_HI = 29;
  localparam int STATE_LO = 25;
  localparam int LRU_HI   = 21;
  localparam int LRU_LO   = 14;

  typedef enum logic [2:0] {
    ST_INV  = 3'd0,
    ST_CSHR = 3'd1,
    ST_NCEC = 3'd2,
    ST_NCED = 3'd3,
    ST_CEC  = 3'd4,
    ST_CED  = 3'd5,
    ST_BAD  = 3'd7
  } stateCode_e;

  typedef struct packed {
    logic             load;
    logic             clearAcc;
    logic             takeLru;
    logic             lastWay;
    logic [WAY_W-1:0] way;
  } ctrlStrobe_t;

  function automatic stateCode_e decodeState(input logic [4:0] raw);
    case (raw)
      5'h00:   return ST_INV;
      5'h0F:   return ST_CSHR;
      5'h13:   return ST_NCEC;
      5'h19:   return ST_NCED;
      5'h16:   return ST_CEC;
      5'h1C:   return ST_CED;
      default: return ST_BAD;
    endcase
  endfunction

endpackage

// File: rtl/dctag_ctrl.sv
module dctag_ctrl
  import dctag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tagValid,
  input  logic        setStart,
  output ctrlStrobe_t strb
);

  logic [WAY_W-1:0] wayCnt;
  logic [WAY_W-1:0] curWay;

  assign curWay = setStart ? '0 : wayCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wayCnt <= '0;
    end else if (tagValid) begin
      wayCnt <= (curWay == WAY_W'(NUM_WAYS - 1)) ? '0 : curWay + 1'b1;
    end
  end

  always_comb begin
    strb.load     = tagValid;
    strb.clearAcc = tagValid && setStart;
    strb.takeLru  = tagValid && (curWay == '0);
    strb.lastWay  = tagValid && (curWay == WAY_W'(NUM_WAYS - 1));
    strb.way      = curWay;
  end

endmodule

// File: rtl/dctag_dp.sv
module dctag_dp
  import dctag_pkg::*;
#(
  parameter int TAG_HI_W = 32,
  parameter int TAG_LO_W = 40,
  parameter int PTAG_LSB = 13,
  parameter int UPAR_LO  = 26,
  parameter int UPAR_BIT = 11,
  parameter int LPAR_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           strb,
  input  logic [TAG_HI_W-1:0]   tagHi,
  input  logic [TAG_LO_W-1:0]   tagLo,
  input  logic [PTAG_LSB-1:0]   setIdx,
  output logic                  outValid,
  output logic [WAY_W-1:0]      outWay,
  output stateCode_e            stateCode,
  output logic                  wayStateErr,
  output logic                  wayAddrErr,
  output logic [TAG_LO_W-1:0]   physAddr,
  output logic                  setStateErr,
  output logic                  setAddrErr,
  output logic [LRU_HI-LRU_LO:0] lruOrder,
  output logic                  setDone
);

  localparam int LRU_W = LRU_HI - LRU_LO + 1;

  stateCode_e nxtCode;
  logic       stateBad;
  logic       upperBad;
  logic       lowerBad;
  logic       addrBad;
  logic       accS;
  logic       accA;
  logic [TAG_HI_W-LRU_W-5-1:0] unusedHi;
  logic [PTAG_LSB-2-1:0]        unusedLo;

  assign unusedHi = {tagHi[TAG_HI_W-1:STATE_HI+1], tagHi[STATE_LO-1:LRU_HI+1],
                     tagHi[LRU_LO-1:0]};
  assign unusedLo = {tagLo[PTAG_LSB-1:UPAR_BIT+1], tagLo[LPAR_BIT-1:0]};

  assign nxtCode  = decodeState(tagHi[STATE_HI:STATE_LO]);
  assign stateBad = (nxtCode == ST_BAD);
  assign upperBad = (^tagLo[TAG_LO_W-1:UPAR_LO]) ^ tagLo[UPAR_BIT];
  assign lowerBad = (^tagLo[UPAR_LO-1:PTAG_LSB]) ^ tagLo[LPAR_BIT];
  assign addrBad  = !stateBad && (upperBad || lowerBad);

  // Flags from earlier beats are dropped on a new set
  assign accS = strb.clearAcc ? 1'b0 : setStateErr;
  assign accA = strb.clearAcc ? 1'b0 : setAddrErr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outWay      <= '0;
      stateCode   <= ST_INV;
      wayStateErr <= 1'b0;
      wayAddrErr  <= 1'b0;
      physAddr    <= '0;
      setStateErr <= 1'b0;
      setAddrErr  <= 1'b0;
      lruOrder    <= '0;
      setDone     <= 1'b0;
    end else begin
      outValid <= strb.load;
      setDone  <= strb.lastWay;
      if (strb.load) begin
        outWay      <= strb.way;
        stateCode   <= nxtCode;
        wayStateErr <= stateBad;
        wayAddrErr  <= addrBad;
        physAddr    <= {tagLo[TAG_LO_W-1:PTAG_LSB], setIdx};
        setStateErr <= accS | stateBad;
        setAddrErr  <= accA | addrBad;
      end
      if (strb.takeLru) begin
        lruOrder <= tagHi[LRU_HI:LRU_LO];
      end
    end
  end

endmodule

// File: rtl/dctag_validator.sv
module dctag_validator
  import dctag_pkg::*;
#(
  parameter int TAG_HI_W = 32,
  parameter int TAG_LO_W = 40,
  parameter int PTAG_LSB = 13,
  parameter int UPAR_LO  = 26,
  parameter int UPAR_BIT = 11,
  parameter int LPAR_BIT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tagValid,
  input  logic                setStart,
  input  logic [TAG_HI_W-1:0] tagHi,
  input  logic [TAG_LO_W-1:0] tagLo,
  input  logic [PTAG_LSB-1:0] setIdx,
  output logic                outValid,
  output logic [WAY_W-1:0]    outWay,
  output logic [2:0]          stateCode,
  output logic                wayStateErr,
  output logic                wayAddrErr,
  output logic [TAG_LO_W-1:0] physAddr,
  output logic                setStateErr,
  output logic                setAddrErr,
  output logic [7:0]          lruOrder,
  output logic                setDone
);

  ctrlStrobe_t strb;
  stateCode_e  codeQ;

  dctag_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tagValid (tagValid),
    .setStart (setStart),
    .strb     (strb)
  );

  dctag_dp #(
    .TAG_HI_W (TAG_HI_W),
    .TAG_LO_W (TAG_LO_W),
    .PTAG_LSB (PTAG_LSB),
    .UPAR_LO  (UPAR_LO),
    .UPAR_BIT (UPAR_BIT),
    .LPAR_BIT (LPAR_BIT)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .tagHi       (tagHi),
    .tagLo       (tagLo),
    .setIdx      (setIdx),
    .outValid    (outValid),
    .outWay      (outWay),
    .stateCode   (codeQ),
    .wayStateErr (wayStateErr),
    .wayAddrErr  (wayAddrErr),
    .physAddr    (physAddr),
    .setStateErr (setStateErr),
    .setAddrErr  (setAddrErr),
    .lruOrder    (lruOrder),
    .setDone     (setDone)
  );

  assign stateCode = codeQ;

endmodule

// File: rtl/dctag_validator_chk.sv
module dctag_validator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tagValid,
  input logic       setStart,
  input logic       outValid,
  input logic [1:0] outWay,
  input logic [2:0] stateCode,
  input logic       wayStateErr,
  input logic       wayAddrErr,
  input logic       setStateErr,
  input logic       setAddrErr,
  input logic [7:0] lruOrder,
  input logic       setDone
);

  a_r8_result_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tagValid |=> outValid);

  a_r8_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    !tagValid |=> !outValid);

  a_r8_done_on_last_way: assert property (@(posedge clk) disable iff (!rst_n)
    setDone |-> (outValid && outWay == 2'd3));

  a_r8_start_is_way0: assert property (@(posedge clk) disable iff (!rst_n)
    (tagValid && setStart) |=> (outWay == 2'd0));

  a_r2_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && wayStateErr) |-> !wayAddrErr);

  a_r1_error_code: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (wayStateErr == (stateCode == 3'd7)));

  a_r6_state_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tagValid && !setStart && setStateErr) |=> setStateErr);

  a_r6_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tagValid && !setStart && setAddrErr) |=> setAddrErr);

  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tagValid && setStart) |=> (setStateErr == wayStateErr && setAddrErr == wayAddrErr));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tagValid |=> ($stable(setStateErr) && $stable(setAddrErr)));

  a_r7_idle_lru_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tagValid |=> $stable(lruOrder));

endmodule

bind dctag_validator dctag_validator_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tagValid    (tagValid),
  .setStart    (setStart),
  .outValid    (outValid),
  .outWay      (outWay),
  .stateCode   (stateCode),
  .wayStateErr (wayStateErr),
  .wayAddrErr  (wayAddrErr),
  .setStateErr (setStateErr),
  .setAddrErr  (setAddrErr),
  .lruOrder    (lruOrder),
  .setDone     (setDone)
);

// File: tb/test_dctag_validator.sv
module test_dctag_validator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tagValid = 1'b0;
  logic        setStart = 1'b0;
  logic [31:0] tagHi = '0;
  logic [39:0] tagLo = '0;
  logic [12:0] setIdx = '0;
  logic        outValid;
  logic [1:0]  outWay;
  logic [2:0]  stateCode;
  logic        wayStateErr;
  logic        wayAddrErr;
  logic [39:0] physAddr;
  logic        setStateErr;
  logic        setAddrErr;
  logic [7:0]  lruOrder;
  logic        setDone;

  always #4 clk = ~clk;

  dctag_validator i_dctag_validator (
    .clk(clk), .rst_n(rst_n), .tagValid(tagValid), .setStart(setStart),
    .tagHi(tagHi), .tagLo(tagLo), .setIdx(setIdx), .outValid(outValid),
    .outWay(outWay), .stateCode(stateCode), .wayStateErr(wayStateErr),
    .wayAddrErr(wayAddrErr), .physAddr(physAddr), .setStateErr(setStateErr),
    .setAddrErr(setAddrErr), .lruOrder(lruOrder), .setDone(setDone)
  );

  typedef struct packed {
    logic [1:0]  way;
    logic [2:0]  code;
    logic        sErr;
    logic        aErr;
    logic [39:0] pa;
    logic        accS;
    logic        accA;
    logic [7:0]  lru;
    logic        done;
  } exp_t;

  exp_t q[$];
  int   errs = 0;
  int   checks = 0;
  bit   finished = 0;
  logic [1:0] bWay = '0;
  logic       bAccS = 1'b0;
  logic       bAccA = 1'b0;
  logic [7:0] bLru = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] refCode(input logic [4:0] s);
    case (s)
      5'h00: return 3'd0;
      5'h0F: return 3'd1;
      5'h13: return 3'd2;
      5'h19: return 3'd3;
      5'h16: return 3'd4;
      5'h1C: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [39:0] mkLo(input logic [26:0] ptag, input logic [12:0] junk,
                                       input bit badU, input bit badL);
    logic [39:0] lo;
    lo = {ptag, junk};
    lo[11] = (^lo[39:26]) ^ badU;
    lo[10] = (^lo[25:13]) ^ badL;
    return lo;
  endfunction

  function automatic logic [31:0] mkHi(input logic [4:0] st, input logic [7:0] lru,
                                       input logic [31:0] junk);
    logic [31:0] hi;
    hi = junk;
    hi[29:25] = st;
    hi[21:14] = lru;
    return hi;
  endfunction

  task automatic sendWay(input bit start, input logic [31:0] hi, input logic [39:0] lo,
                         input logic [12:0] idx);
    exp_t e;
    e.way  = start ? 2'd0 : bWay;
    e.code = refCode(hi[29:25]);
    e.sErr = (e.code == 3'd7);
    e.aErr = !e.sErr && (((^lo[39:26]) != lo[11]) || ((^lo[25:13]) != lo[10]));
    e.pa   = {lo[39:13], idx};
    if (start) begin
      bAccS = 1'b0;
      bAccA = 1'b0;
    end
    bAccS = bAccS | e.sErr;
    bAccA = bAccA | e.aErr;
    if (e.way == 2'd0) bLru = hi[21:14];
    e.accS = bAccS;
    e.accA = bAccA;
    e.lru  = bLru;
    e.done = (e.way == 2'd3);
    bWay   = e.way + 2'd1;
    @(negedge clk);
    tagValid = 1'b1;
    setStart = start;
    tagHi    = hi;
    tagLo    = lo;
    setIdx   = idx;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tagValid = 1'b0;
      setStart = 1'b0;
      tagHi    = 32'hFFFF_FFFF;
      tagLo    = '1;
    end
  endtask

  // Monitor: results are due on the edge after the beat
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (outValid) begin
        if (q.size() == 0) begin
          chk("R8 unexpected outValid", 64'(outValid), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R8 outWay", 64'(outWay), 64'(e.way));
          chk("R1 stateCode", 64'(stateCode), 64'(e.code));
          chk("R2 wayStateErr", 64'(wayStateErr), 64'(e.sErr));
          chk("R3/R4 wayAddrErr", 64'(wayAddrErr), 64'(e.aErr));
          chk("R5 physAddr", 64'(physAddr), 64'(e.pa));
          chk("R6 setStateErr", 64'(setStateErr), 64'(e.accS));
          chk("R6 setAddrErr", 64'(setAddrErr), 64'(e.accA));
          chk("R7 lruOrder", 64'(lruOrder), 64'(e.lru));
          chk("R8 setDone", 64'(setDone), 64'(e.done));
        end
      end else begin
        chk("R8 result missing", 64'(q.size()), 64'd0);
        chk("R8 setDone idle", 64'(setDone), 64'd0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 outValid", 64'(outValid), 64'd0);
    chk("R9 setDone", 64'(setDone), 64'd0);
    chk("R9 setStateErr", 64'(setStateErr), 64'd0);
    chk("R9 setAddrErr", 64'(setAddrErr), 64'd0);
    chk("R9 lruOrder", 64'(lruOrder), 64'd0);
    chk("R9 stateCode", 64'(stateCode), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // Clean set, legal states, back to back
    sendWay(1, mkHi(5'h0F, 8'hE4, 32'h1234_5678), mkLo(27'h5A5A5A5, 13'h1FFF, 0, 0), 13'h0040);
    sendWay(0, mkHi(5'h13, 8'h1B, 32'h0),         mkLo(27'h7FFFFFF, 13'h0,    0, 0), 13'h0041);
    sendWay(0, mkHi(5'h19, 8'h00, 32'hFFFF_FFFF), mkLo(27'h0000001, 13'h0AAA, 0, 0), 13'h1FFF);
    sendWay(0, mkHi(5'h16, 8'h55, 32'h0F0F_0F0F), mkLo(27'h4000000, 13'h1555, 0, 0), 13'h0000);
    idle(1);

    // Error set: R3 upper, R2 illegal with bad parity, R4 lower
    sendWay(1, mkHi(5'h1C, 8'h39, 32'h0),         mkLo(27'h0123456, 13'h0,    0, 0), 13'h0100);
    sendWay(0, mkHi(5'h00, 8'hFF, 32'h0),         mkLo(27'h0ABCDEF, 13'h0,    1, 0), 13'h0101);
    idle(2);
    sendWay(0, mkHi(5'h05, 8'hAA, 32'h0),         mkLo(27'h3333333, 13'h0,    1, 1), 13'h0102);
    sendWay(0, mkHi(5'h0F, 8'h11, 32'h0),         mkLo(27'h1111111, 13'h0,    0, 1), 13'h0103);

    // Restart partway through: flags of old set must drop (R6)
    sendWay(1, mkHi(5'h1F, 8'hC6, 32'h0),         mkLo(27'h2222222, 13'h0,    0, 0), 13'h0004);
    sendWay(0, mkHi(5'h0F, 8'h00, 32'h0),         mkLo(27'h2222223, 13'h0,    0, 0), 13'h0005);
    sendWay(1, mkHi(5'h13, 8'h93, 32'h0),         mkLo(27'h2222224, 13'h0,    0, 0), 13'h0006);
    idle(1);

    // Sweep of every state value with mixed parity faults
    for (int s = 0; s < 32; s++) begin
      sendWay(s % 4 == 0,
              mkHi(5'(s), 8'(s * 37 + 3), 32'hA5C3_0000 ^ 32'(s * 32'h0101_0101)),
              mkLo(27'(s * 27'h0123457 + 5), 13'(s * 13'h0597), s % 3 == 1, s % 5 == 2),
              13'(s * 13'h0211));
      if (s % 7 == 3) idle(1 + s % 2);
    end
    idle(3);
    chk("R8 queue drained", 64'(q.size()), 64'd0);
    finish_run();
  end

endmodule